// File: doc/BRIEF.md
# Register-File Read-Address Source Selector

This block decides, every cycle, which origin feeds the address selectors of the two read ports (A and B) of a register file. There are four candidates. The first is the microinstruction's own source codes. The second is a fixed pair picked by instruction phase and type. The third is the stack pointer. The fourth is one of two memory-controller address registers, one for the first pipeline stage and one for the second. The block reports each choice as a pair of 3-bit source codes that the register-file address multiplexers decode.

The block also holds three state bits: a suspend flag and two stage-ownership flags. Suspend is set whenever a memory-controller stage takes the register file, so the processor is held off for that access. From suspend, an abort/phase term and the pending memory requests, the block derives a processor-select condition. That condition says whether the microinstruction may supply the read addresses this cycle.

The codes are combinational from the current inputs and the held flags. The flags update on the rising clock edge and clear on a synchronous active-high reset.

Top module: `rf_read_source`

## Requirements
- R1: `proc_sel` is 1 exactly when ((`abort` and not `cycle0`) or `suspend`) holds and neither `mc1_req` nor `mc2_get` is asserted.
- R2: When `proc_sel` is 1 and no stage grant is active, `a_src`/`b_src` equal `ui_a`/`ui_b`.
- R3: With no grant, `proc_sel`=0, `cycle0`=1, `suspend`=0 and `mem_inst`=0, the pair is A=2, B=5.
- R4: Under the same conditions with `mem_inst`=1, the pair is A=0, B=4 when `rsel_hi` is nonzero, and A=1, B=4 when `rsel_hi` is 0.
- R5: With no grant, `proc_sel`=0 and R3/R4 not applying, the pair is the stack pointer, A=3, B=3.
- R6: A first-stage grant is `mc1_req`=1 with `mc1_xfer`=1. It drives A=4, B=6 ahead of every other source, and on the next edge it sets `mc1_has` and `suspend`.
- R7: A second-stage grant is `mc2_get`=1 with `mc2_xfer`=1 and no first-stage grant. It drives A=6, B=7, and on the next edge it sets `mc2_has` and `suspend`.
- R8: After an edge with no grant, `suspend`, `mc1_has` and `mc2_has` are all 0.
- R9: `mc1_has` and `mc2_has` are never both 1. When both stages request with their transfer flags set, the first stage wins.
- R10: A cycle with `rst`=1 leaves `suspend`, `mc1_has` and `mc2_has` at 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cycle0 | input | 1 | First phase of an instruction |
| abort | input | 1 | Abort condition |
| mem_inst | input | 1 | Current microinstruction is a memory instruction |
| rsel_hi | input | 2 | Upper two register-select bits of the microinstruction |
| ui_a | input | 3 | Microinstruction-supplied A source code |
| ui_b | input | 3 | Microinstruction-supplied B source code |
| mc1_req | input | 1 | First memory stage needs the register file |
| mc1_xfer | input | 1 | First stage transfer-word flag |
| mc2_get | input | 1 | Second memory stage will take the register file |
| mc2_xfer | input | 1 | Second stage transfer-word flag |
| a_src | output | 3 | Selected A-port source code |
| b_src | output | 3 | Selected B-port source code |
| proc_sel | output | 1 | Microinstruction owns the register file |
| suspend | output | 1 | Processor held for a memory access |
| mc1_has | output | 1 | First stage held the register file last cycle |
| mc2_has | output | 1 | Second stage held the register file last cycle |

## Verification
The properties assume that every input is a settled 0 or 1 at each rising edge and that `rst` is high at the first edge. The bench changes inputs only on falling edges and holds reset across the first edges. Apart from those two conditions, any combination of requests, transfer flags and phase bits is legal. The bench therefore draws requests at a reduced rate, so that the instruction-phase and stack paths are also reached often.

// File: rtl/rfrs_pkg.sv
package rfrs_pkg;
    localparam int CODE_W = 3;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        code_t a;
        code_t b;
    } pair_t;

    typedef enum logic [2:0] {
        ORG_MC1,
        ORG_MC2,
        ORG_UINST,
        ORG_INSTR,
        ORG_STACK
    } origin_e;

    localparam pair_t PAIR_MC1   = '{a: 3'd4, b: 3'd6};
    localparam pair_t PAIR_MC2   = '{a: 3'd6, b: 3'd7};
    localparam pair_t PAIR_STACK = '{a: 3'd3, b: 3'd3};

    function automatic pair_t instr_pair(input logic mem_inst, input logic [1:0] rsel_hi);
        pair_t p;
        if (!mem_inst)          p = '{a: 3'd2, b: 3'd5};
        else if (rsel_hi != 0)  p = '{a: 3'd0, b: 3'd4};
        else                    p = '{a: 3'd1, b: 3'd4};
        return p;
    endfunction
endpackage

// File: rtl/rfrs_grant.sv
module rfrs_grant (
    input  logic mc1_req,
    input  logic mc1_xfer,
    input  logic mc2_get,
    input  logic mc2_xfer,
    output logic grant1,
    output logic grant2,
    output logic mem_needs
);
    always_comb begin
        grant1    = mc1_req & mc1_xfer;
        grant2    = ~grant1 & mc2_get & mc2_xfer;
        mem_needs = mc1_req | mc2_get;
    end
endmodule

// File: rtl/rfrs_state.sv
module rfrs_state (
    input  logic clk,
    input  logic rst,
    input  logic grant1,
    input  logic grant2,
    output logic suspend,
    output logic mc1_has,
    output logic mc2_has
);
    always_ff @(posedge clk) begin
        if (rst) begin
            suspend <= 1'b0;
            mc1_has <= 1'b0;
            mc2_has <= 1'b0;
        end else begin
            suspend <= grant1 | grant2;
            mc1_has <= grant1;
            mc2_has <= grant2;
        end
    end
endmodule

// File: rtl/rfrs_mux.sv
module rfrs_mux
    import rfrs_pkg::*;
(
    input  logic        grant1,
    input  logic        grant2,
    input  logic        proc_sel,
    input  logic        cycle0,
    input  logic        suspend,
    input  logic        mem_inst,
    input  logic [1:0]  rsel_hi,
    input  code_t       ui_a,
    input  code_t       ui_b,
    output pair_t       pair
);
    origin_e org;

    always_comb begin
        if (grant1)                   org = ORG_MC1;
        else if (grant2)              org = ORG_MC2;
        else if (proc_sel)            org = ORG_UINST;
        else if (cycle0 && !suspend)  org = ORG_INSTR;
        else                          org = ORG_STACK;
    end

    always_comb begin
        unique case (org)
            ORG_MC1:   pair = PAIR_MC1;
            ORG_MC2:   pair = PAIR_MC2;
            ORG_UINST: pair = '{a: ui_a, b: ui_b};
            ORG_INSTR: pair = instr_pair(mem_inst, rsel_hi);
            default:   pair = PAIR_STACK;
        endcase
    end
endmodule

// File: rtl/rf_read_source.sv
module rf_read_source
    import rfrs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cycle0,
    input  logic        abort,
    input  logic        mem_inst,
    input  logic [1:0]  rsel_hi,
    input  logic [2:0]  ui_a,
    input  logic [2:0]  ui_b,
    input  logic        mc1_req,
    input  logic        mc1_xfer,
    input  logic        mc2_get,
    input  logic        mc2_xfer,
    output logic [2:0]  a_src,
    output logic [2:0]  b_src,
    output logic        proc_sel,
    output logic        suspend,
    output logic        mc1_has,
    output logic        mc2_has
);
    logic  grant1, grant2, mem_needs;
    pair_t pair;

    rfrs_grant u_grant (
        .mc1_req(mc1_req), .mc1_xfer(mc1_xfer),
        .mc2_get(mc2_get), .mc2_xfer(mc2_xfer),
        .grant1(grant1), .grant2(grant2), .mem_needs(mem_needs)
    );

    rfrs_state u_state (
        .clk(clk), .rst(rst), .grant1(grant1), .grant2(grant2),
        .suspend(suspend), .mc1_has(mc1_has), .mc2_has(mc2_has)
    );

    assign proc_sel = ((abort & ~cycle0) | suspend) & ~mem_needs;

    rfrs_mux u_mux (
        .grant1(grant1), .grant2(grant2), .proc_sel(proc_sel),
        .cycle0(cycle0), .suspend(suspend), .mem_inst(mem_inst),
        .rsel_hi(rsel_hi), .ui_a(ui_a), .ui_b(ui_b), .pair(pair)
    );

    assign a_src = pair.a;
    assign b_src = pair.b;
endmodule

// File: rtl/rfrs_chk.sv
module rfrs_chk (
    input logic       clk,
    input logic       rst,
    input logic       mc1_req,
    input logic       mc1_xfer,
    input logic       mc2_get,
    input logic       mc2_xfer,
    input logic [2:0] ui_a,
    input logic [2:0] ui_b,
    input logic [2:0] a_src,
    input logic [2:0] b_src,
    input logic       proc_sel,
    input logic       suspend,
    input logic       mc1_has,
    input logic       mc2_has
);
    // R9
    has_mutex_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mc1_has, mc2_has}));
    // R6
    mc1_codes_chk: assert property (@(posedge clk) disable iff (rst)
        (mc1_req && mc1_xfer) |-> (a_src == 3'd4 && b_src == 3'd6));
    // R6
    mc1_set_chk: assert property (@(posedge clk) disable iff (rst)
        (mc1_req && mc1_xfer) |=> (mc1_has && suspend));
    // R7
    mc2_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!(mc1_req && mc1_xfer) && mc2_get && mc2_xfer) |=> (mc2_has && suspend && !mc1_has));
    // R8
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !((mc1_req && mc1_xfer) || (mc2_get && mc2_xfer)) |=> (!suspend && !mc1_has && !mc2_has));
    // R2
    uinst_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (proc_sel && !(mc1_req && mc1_xfer) && !(mc2_get && mc2_xfer)) |-> (a_src == ui_a && b_src == ui_b));
    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!suspend && !mc1_has && !mc2_has));
endmodule

bind rf_read_source rfrs_chk u_chk (
    .clk(clk), .rst(rst), .mc1_req(mc1_req), .mc1_xfer(mc1_xfer),
    .mc2_get(mc2_get), .mc2_xfer(mc2_xfer), .ui_a(ui_a), .ui_b(ui_b),
    .a_src(a_src), .b_src(b_src), .proc_sel(proc_sel), .suspend(suspend),
    .mc1_has(mc1_has), .mc2_has(mc2_has)
);

// File: tb/rf_read_source_test.sv
module rf_read_source_test;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cycle0 = 0, abort = 0, mem_inst = 0, mc1_req = 0, mc1_xfer = 0, mc2_get = 0, mc2_xfer = 0;
    logic [1:0] rsel_hi = 0;
    logic [2:0] ui_a = 0, ui_b = 0;
    logic [2:0] a_src, b_src;
    logic proc_sel, suspend, mc1_has, mc2_has;

    int checks = 0, errors = 0;
    logic m_susp = 0, m_h1 = 0, m_h2 = 0;

    always #(PERIOD/2) clk = ~clk;

    rf_read_source uut (
        .clk(clk), .rst(rst), .cycle0(cycle0), .abort(abort), .mem_inst(mem_inst),
        .rsel_hi(rsel_hi), .ui_a(ui_a), .ui_b(ui_b), .mc1_req(mc1_req), .mc1_xfer(mc1_xfer),
        .mc2_get(mc2_get), .mc2_xfer(mc2_xfer), .a_src(a_src), .b_src(b_src),
        .proc_sel(proc_sel), .suspend(suspend), .mc1_has(mc1_has), .mc2_has(mc2_has)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic exp_psel();
        return ((abort && !cycle0) || m_susp) && !(mc1_req || mc2_get);
    endfunction

    // expected {a,b} and the requirement governing it
    function automatic logic [5:0] exp_pair(output string tag);
        logic g1, g2;
        g1 = mc1_req && mc1_xfer;
        g2 = !g1 && mc2_get && mc2_xfer;
        if (g1)               begin tag = "R6 codes"; return {3'd4, 3'd6}; end
        if (g2)               begin tag = "R7 codes"; return {3'd6, 3'd7}; end
        if (exp_psel())       begin tag = "R2 codes"; return {ui_a, ui_b}; end
        if (cycle0 && !m_susp) begin
            if (!mem_inst)    begin tag = "R3 codes"; return {3'd2, 3'd5}; end
            tag = "R4 codes";
            return (rsel_hi != 0) ? {3'd0, 3'd4} : {3'd1, 3'd4};
        end
        tag = "R5 codes";
        return {3'd3, 3'd3};
    endfunction

    // inputs already driven after a falling edge; check, then cross the rising edge
    task automatic step();
        string t;
        logic [5:0] e;
        logic g1, g2;
        #1;
        if (!rst) begin
            e = exp_pair(t);
            chk(t, {a_src, b_src}, e);
            chk("R1 proc_sel", proc_sel, exp_psel());
            chk("R8 suspend", suspend, m_susp);
            chk("R9 mc1_has", mc1_has, m_h1);
            chk("R9 mc2_has", mc2_has, m_h2);
        end
        g1 = mc1_req && mc1_xfer;
        g2 = !g1 && mc2_get && mc2_xfer;
        @(posedge clk);
        if (rst) begin m_susp = 0; m_h1 = 0; m_h2 = 0; end
        else begin m_susp = g1 || g2; m_h1 = g1; m_h2 = g2; end
        @(negedge clk);
    endtask

    task automatic quiet();
        mc1_req = 0; mc1_xfer = 0; mc2_get = 0; mc2_xfer = 0;
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        @(negedge clk);
        step(); step();
        rst = 0;
        #1;
        chk("R10 reset suspend", suspend, 0);
        chk("R10 reset mc1_has", mc1_has, 0);
        chk("R10 reset mc2_has", mc2_has, 0);
        // sweep of phase, suspend, type and select bits
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < 2; c++)
                for (int m = 0; m < 2; m++)
                    for (int r = 0; r < 4; r++) begin
                        quiet();
                        if (s == 1) begin mc1_req = 1; mc1_xfer = 1; step(); quiet(); end
                        cycle0 = c[0]; mem_inst = m[0]; rsel_hi = r[1:0]; abort = 0;
                        ui_a = 3'(r + 1); ui_b = 3'(7 - r);
                        step();
                    end
        // R9 both stages request: first stage wins
        quiet(); mc1_req = 1; mc1_xfer = 1; mc2_get = 1; mc2_xfer = 1; step();
        // R7 second stage alone, then R8 idle
        quiet(); mc2_get = 1; mc2_xfer = 1; step();
        quiet(); step();
        // R8 request without transfer flag clears suspend
        mc1_req = 1; mc1_xfer = 1; step();
        quiet(); mc1_req = 1; step();
        // R10 reset while flags set
        quiet(); mc2_get = 1; mc2_xfer = 1; step();
        rst = 1; quiet(); step(); rst = 0; step();
        // random
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] v;
            v = $urandom();
            cycle0 = v[0]; abort = v[1]; mem_inst = v[2]; rsel_hi = v[4:3];
            ui_a = v[7:5]; ui_b = v[10:8];
            mc1_req = (v[13:11] == 0); mc1_xfer = v[14];
            mc2_get = (v[17:15] == 0); mc2_xfer = v[18];
            step();
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule